// File: doc/BRIEF.md
# Byte-Lane Synchronous Work RAM

This block is a single-port work memory that sits as a slave on a 16-bit data bus. Each bus device receives an active-low select from an external address decoder, plus a local word address, a read/write flag and two active-low byte strobes. Full-word writes happen when both strobes are low. Single-byte writes happen when only one strobe is low, and the other byte stays as it was.

Reads are registered: the array is sampled on the clock edge that sees a selected read. The word appears on `rd_data` for the following cycle. In every other cycle the output is forced to zero, so several slaves can have their read buses OR-ed together.

Depth is a power of two set by `DEPTH_LOG2`. Setting it to 15 gives the full 64 KB (32K words). The default of 10 keeps elaboration small. Address bits above the configured depth are ignored, so the memory repeats across the local address window.

Top module: `lane_ram`

## Requirements
- R1: After reset, and before any read has been sampled, `rd_data` is 16'h0000.
- R2: On a clock edge where `sel_n`=0, `rd_wr`=0, `ub_n`=0 and `lb_n`=0, all 16 bits of `wr_data` are stored at the addressed word. A later read of that word returns them.
- R3: Byte lanes are written independently. When only `lb_n` is 0, bits 7..0 are stored and bits 15..8 of the word keep their old value. When only `ub_n` is 0, bits 15..8 are stored and bits 7..0 keep their old value.
- R4: Nothing is stored on an edge where `sel_n`=1, or where `rd_wr`=1, or where both strobes are 1.
- R5: A read sampled on edge N (`sel_n`=0, `rd_wr`=1) puts the full stored word on `rd_data` after edge N. It stays there until edge N+1. The strobes do not mask read data.
- R6: After any edge where the block is not doing a selected read (`sel_n`=1, or `rd_wr`=0), `rd_data` is 16'h0000 until the next edge.
- R7: A write on one edge followed by a read of the same word on the next edge returns the newly written data.
- R8: Only the low `DEPTH_LOG2` bits of `addr` select a word. Addresses that differ only in higher bits reach the same storage.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| sel_n | input | 1 | Active-low device select from the bus decoder |
| rd_wr | input | 1 | 1 = read cycle, 0 = write cycle |
| ub_n | input | 1 | Active-low strobe for data bits 15..8 |
| lb_n | input | 1 | Active-low strobe for data bits 7..0 |
| addr | input | ADDR_W (16) | Local word address |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Registered read data, zero when not returning a read |

## Verification
The bench targets the following corner cases and the failure each one would expose:

- **Single-byte writes.** A design that ignored a strobe would corrupt the neighbouring byte, and the readback would show the wrong upper or lower half.
- **Writes that must not land.** These are a write with the select high, and a selected write with both strobes high. A design that forgot the select would overwrite the word, the classic mistake of a write-anywhere trigger.
- **Zero-when-idle output.** The bench checks zero after writes and after deselected cycles. A design that left the last read word on the bus would break wired-OR sharing.
- **Write then immediate read.** This catches stale data from a read that bypasses the fresh write.
- **Aliasing.** Addresses one depth apart must read the same data. This catches masking with the wrong bits.

// File: rtl/lane_ram_pkg.sv
package lane_ram_pkg;
  localparam int LANE_W   = 8;
  localparam int LANES    = 2;
  localparam int BUS_W    = LANE_W * LANES;
  localparam int LANE_LO  = 0;
  localparam int LANE_HI  = 1;
endpackage

// File: rtl/lane_ram_ctrl.sv
module lane_ram_ctrl
  import lane_ram_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_n,
  input  logic             rd_wr,
  input  logic             ub_n,
  input  logic             lb_n,
  output logic [LANES-1:0] lane_we,
  output logic             rd_req,
  output logic             rd_valid
);
  logic rd_valid_d;

  always_comb begin
    lane_we          = '0;
    lane_we[LANE_LO] = !sel_n && !rd_wr && !lb_n;
    lane_we[LANE_HI] = !sel_n && !rd_wr && !ub_n;
    rd_req           = !sel_n && rd_wr;
    rd_valid_d       = rd_req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_valid <= 1'b0;
    else        rd_valid <= rd_valid_d;
  end

  // a read request is never also a lane write
  assert_rd_excl_wr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> (lane_we == '0));
endmodule

// File: rtl/lane_ram_bank.sv
module lane_ram_bank #(
  parameter int DEPTH_LOG2 = 10,
  parameter int WIDTH      = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  we,
  input  logic                  re,
  input  logic [DEPTH_LOG2-1:0] idx,
  input  logic [WIDTH-1:0]      wdata,
  output logic [WIDTH-1:0]      q
);
  localparam int DEPTH = 1 << DEPTH_LOG2;

  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[idx] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) q <= mem[idx];
  end

  assert_lane_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (mem[$past(idx)] === $past(wdata)));

  assert_lane_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> (mem[$past(idx)] === $past(mem[idx])));
endmodule

// File: rtl/lane_ram.sv
module lane_ram
  import lane_ram_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DEPTH_LOG2 = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_n,
  input  logic              rd_wr,
  input  logic              ub_n,
  input  logic              lb_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BUS_W-1:0]  wr_data,
  output logic [BUS_W-1:0]  rd_data
);
  logic [LANES-1:0]      lane_we;
  logic                  rd_req;
  logic                  rd_valid;
  logic [DEPTH_LOG2-1:0] word_idx;
  logic [BUS_W-1:0]      q_word;

  assign word_idx = addr[DEPTH_LOG2-1:0];

  lane_ram_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel_n    (sel_n),
    .rd_wr    (rd_wr),
    .ub_n     (ub_n),
    .lb_n     (lb_n),
    .lane_we  (lane_we),
    .rd_req   (rd_req),
    .rd_valid (rd_valid)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    lane_ram_bank #(
      .DEPTH_LOG2 (DEPTH_LOG2),
      .WIDTH      (LANE_W)
    ) u_bank (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (lane_we[g]),
      .re    (rd_req),
      .idx   (word_idx),
      .wdata (wr_data[g*LANE_W +: LANE_W]),
      .q     (q_word[g*LANE_W +: LANE_W])
    );
  end

  always_comb begin
    rd_data = rd_valid ? q_word : '0;
  end

  assert_idle_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_n || !rd_wr) |=> (rd_data == '0));

  assert_fresh_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_n && !rd_wr && !ub_n && !lb_n) ##1
    (!sel_n && rd_wr && addr == $past(addr)) |=> (rd_data == $past(wr_data, 2)));
endmodule

// File: tb/lane_ram_bench.sv
module lane_ram_bench;
  localparam int AW = 16;
  localparam int DL = 10;

  logic          clk;
  logic          rst_n;
  logic          sel_n;
  logic          rd_wr;
  logic          ub_n;
  logic          lb_n;
  logic [AW-1:0] addr;
  logic [15:0]   wr_data;
  logic [15:0]   rd_data;

  int tests_run = 0;
  int tests_bad = 0;
  bit done      = 0;

  logic [15:0] exp_q[$];
  string       tag_q[$];

  lane_ram #(.ADDR_W(AW), .DEPTH_LOG2(DL)) u_lane_ram (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel_n   (sel_n),
    .rd_wr   (rd_wr),
    .ub_n    (ub_n),
    .lb_n    (lb_n),
    .addr    (addr),
    .wr_data (wr_data),
    .rd_data (rd_data)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input logic [15:0] got, input logic [15:0] exp, input string tag);
    tests_run++;
    if (got !== exp) begin
      tests_bad++;
      $display("FAIL %s: rd_data=%h expected=%h", tag, got, exp);
    end
  endtask

  // monitor: one expected item per driven cycle, compared after the edge
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [15:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(rd_data, e, t);
    end
  end

  task automatic drive(input logic s_n, input logic rw, input logic u_n, input logic l_n,
                       input logic [AW-1:0] a, input logic [15:0] d,
                       input logic [15:0] exp, input string tag);
    @(negedge clk);
    sel_n = s_n; rd_wr = rw; ub_n = u_n; lb_n = l_n; addr = a; wr_data = d;
    @(posedge clk);
    #1;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [15:0] d, input logic u_n, input logic l_n);
    drive(1'b0, 1'b0, u_n, l_n, a, d, 16'h0000, "R6 write");
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [15:0] exp, input string tag);
    drive(1'b0, 1'b1, 1'b1, 1'b1, a, 16'hDEAD, exp, tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests_run, tests_bad);
      $finish;
    end
  endtask

  initial begin
    #400000;
    tests_run++;
    tests_bad++;
    $display("FAIL watchdog: rd_data=%h expected=end of run", rd_data);
    finish_run();
  end

  initial begin
    rst_n = 1'b0; sel_n = 1'b1; rd_wr = 1'b1; ub_n = 1'b1; lb_n = 1'b1;
    addr = '0; wr_data = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    check(rd_data, 16'h0000, "R1 reset");
    @(negedge clk);
    check(rd_data, 16'h0000, "R1 after release");

    // R2 full word
    wr(16'd5, 16'h1234, 1'b0, 1'b0);
    drive(1'b1, 1'b1, 1'b1, 1'b1, 16'd0, 16'h0, 16'h0000, "R6 idle");
    rd(16'd5, 16'h1234, "R2 full word");
    // R5 back-to-back reads and latency
    wr(16'd6, 16'h5678, 1'b0, 1'b0);
    rd(16'd5, 16'h1234, "R5 read A");
    rd(16'd6, 16'h5678, "R5 read B");
    drive(1'b1, 1'b1, 1'b1, 1'b1, 16'd6, 16'h0, 16'h0000, "R6 deselected");
    // R7 write then immediate read
    wr(16'd9, 16'hA5C3, 1'b0, 1'b0);
    rd(16'd9, 16'hA5C3, "R7 fresh read");
    // R3 byte lanes
    wr(16'd20, 16'hBEEF, 1'b0, 1'b0);
    wr(16'd20, 16'h7711, 1'b1, 1'b0);
    rd(16'd20, 16'hBE11, "R3 lower lane only");
    wr(16'd20, 16'h22FF, 1'b0, 1'b1);
    rd(16'd20, 16'h2211, "R3 upper lane only");
    // R4 ignored writes
    drive(1'b1, 1'b0, 1'b0, 1'b0, 16'd20, 16'hFFFF, 16'h0000, "R6 deselected write");
    rd(16'd20, 16'h2211, "R4 deselected write ignored");
    wr(16'd20, 16'h0000, 1'b1, 1'b1);
    rd(16'd20, 16'h2211, "R4 no strobe write ignored");
    // R5 strobes do not mask reads
    drive(1'b0, 1'b1, 1'b0, 1'b1, 16'd20, 16'h0, 16'h2211, "R5 strobes ignored on read");
    // R8 aliasing
    wr(16'd3, 16'h0F0F, 1'b0, 1'b0);
    rd(16'd3 + 16'd1024, 16'h0F0F, "R8 alias read");
    wr(16'hFC03, 16'hABCD, 1'b0, 1'b0);
    rd(16'd3, 16'hABCD, "R8 alias write");
    drive(1'b1, 1'b1, 1'b1, 1'b1, 16'd0, 16'h0, 16'h0000, "R6 final idle");
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule